// File: doc/BRIEF.md
# Converter Output Formatter with Test Patterns

This block sits at the end of one 12-bit converter channel. Each clock it takes a raw offset-binary sample and its out-of-range flag. It can replace the sample with a built-in or user-programmed test word. It then recodes the word as offset binary, two's complement or Gray code. The result leaves the block either as a full parallel word or as bit pairs on half as many double-data-rate lanes. A data-valid strobe goes with the data so the receiver can capture it.

The path through the block has a fixed register latency, set by a parameter that defaults to 14 clock edges. Each sample carries its own pattern and code choices through the pipeline, so a change of configuration takes effect on a sample boundary. The code can be chosen in one of two ways. In register mode a two-bit selector picks the code. In pin mode a single level picks offset binary or two's complement, and Gray code cannot be reached.

Top module: `cvt_out_fmt`

## Requirements
- R1: While `rst_n` is low, `par_o`, `ddr_o` and `ovr_o` are all zero. The pipeline then presents zeros until the first sample taken after reset reaches the output.
- R2: A sample and its configuration held across rising edge k appear at the outputs just after rising edge k+LATENCY-1. This is LATENCY register stages, 14 by default.
- R3: In register mode the code follows `fmt_sel_i`: 00 gives offset binary unchanged, 01 gives two's complement (MSB inverted), 10 gives Gray code (w XOR (w>>1)), and 11 gives offset binary.
- R4: When `pin_mode_i` is 1, `fmt_sel_i` is ignored. In that case `dfs_i`=0 selects offset binary and `dfs_i`=1 selects two's complement.
- R5: `pat_sel_i` picks the word before recoding. 000 and 111 pass the sample. 001 gives midscale 0x800, 010 gives 0xFFF, 011 gives 0x000, and 101 gives `user_pat_i`.
- R6: Code 100 gives a checkerboard. The word is 0xAAA when a phase bit is 0 and 0x555 when it is 1. The phase bit is 0 at the first edge after reset and flips on every edge, whatever the selection.
- R7: Code 110 gives a ramp. A free-running 12-bit counter is 0 at the first edge after reset, adds one on every edge and wraps at 0xFFF.
- R8: For pattern codes 001 to 110, `ovr_o` is forced to 0. Otherwise `ovr_o` follows `ovr_i`. In both cases it has the same latency as the data.
- R9: In DDR mode (`ddr_mode_i`=1), lane i drives bit 2i while `clk` is high and bit 2i+1 while `clk` is low, and `par_o` is held at 0.
- R10: In parallel mode (`ddr_mode_i`=0), `par_o` carries the formatted word and `ddr_o` is held at 0.
- R11: `dav_o` equals `~clk` in parallel mode and equals the quadrature clock `dav_qclk_i` in DDR mode. Either way, its edges fall in the middle of each data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dav_qclk_i | input | 1 | Clock shifted a quarter period, used as the DDR strobe |
| smp_i | input | W | Raw offset-binary sample |
| ovr_i | input | 1 | Out-of-range flag for the sample |
| pat_sel_i | input | 3 | Test pattern selector |
| user_pat_i | input | W | User-programmed test word |
| fmt_sel_i | input | 2 | Output code in register mode |
| pin_mode_i | input | 1 | 1: code taken from `dfs_i` |
| dfs_i | input | 1 | Pin-mode code: 0 offset binary, 1 two's complement |
| ddr_mode_i | input | 1 | 1: paired DDR lanes, 0: parallel word |
| par_o | output | W | Parallel output word |
| ddr_o | output | W/2 | DDR lanes |
| ovr_o | output | 1 | Delayed out-of-range flag |
| dav_o | output | 1 | Data-valid strobe |

## Verification
The bench changes pattern, code and pin-mode settings between consecutive samples. A design that applied the configuration at the encoder stage, and not together with the sample, would then recode a sample one edge early or late. A latency that is off by one register shows up as a mismatch on every randomly varying sample. The phase of the checkerboard and ramp is checked against a count of edges since reset, which catches a generator that only runs while it is selected. The DDR lanes are sampled in both halves of the clock, which exposes swapped even/odd bits. The bench drives `fmt_sel_i`=10 during pin mode, which exposes any leak of Gray code into pin mode.

// File: rtl/cof_pkg.sv
package cof_pkg;
  typedef enum logic [1:0] {
    FMT_OBIN = 2'b00,
    FMT_TWOS = 2'b01,
    FMT_GRAY = 2'b10
  } fmt_e;

  localparam logic [2:0] PAT_OFF  = 3'b000;
  localparam logic [2:0] PAT_MID  = 3'b001;
  localparam logic [2:0] PAT_ONES = 3'b010;
  localparam logic [2:0] PAT_ZERO = 3'b011;
  localparam logic [2:0] PAT_CHK  = 3'b100;
  localparam logic [2:0] PAT_USER = 3'b101;
  localparam logic [2:0] PAT_RAMP = 3'b110;
  localparam logic [2:0] PAT_OFF2 = 3'b111;
endpackage

// File: rtl/cof_pattern_gen.sv
module cof_pattern_gen
  import cof_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp_i,
  input  logic         ovr_i,
  input  logic [2:0]   pat_sel_i,
  input  logic [W-1:0] user_pat_i,
  input  fmt_e         fmt_i,
  output logic [W-1:0] word_q,
  output logic         ovr_q,
  output fmt_e         fmt_q,
  output logic [W-1:0] ramp_q,
  output logic         phase_q
);
  localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] chk_w;
  logic [W-1:0] word_d;
  logic [W-1:0] ramp_d;
  logic         ovr_d;
  logic         phase_d;
  logic         pat_on;

  for (genvar gi = 0; gi < W; gi++) begin : g_chk
    assign chk_w[gi] = phase_q ^ ((gi % 2) != 0);
  end

  always_comb begin
    ramp_d  = ramp_q + 1'b1;
    phase_d = ~phase_q;
    pat_on  = (pat_sel_i != PAT_OFF) && (pat_sel_i != PAT_OFF2);
    word_d  = smp_i;
    case (pat_sel_i)
      PAT_MID:  word_d = MIDSCALE;
      PAT_ONES: word_d = '1;
      PAT_ZERO: word_d = '0;
      PAT_CHK:  word_d = chk_w;
      PAT_USER: word_d = user_pat_i;
      PAT_RAMP: word_d = ramp_q;
      default:  word_d = smp_i;
    endcase
    ovr_d = ovr_i & ~pat_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ovr_q   <= 1'b0;
      fmt_q   <= FMT_OBIN;
      ramp_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      ovr_q   <= ovr_d;
      fmt_q   <= fmt_i;
      ramp_q  <= ramp_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/cof_encoder.sv
module cof_encoder
  import cof_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  input  logic         ovr_i,
  input  fmt_e         fmt_i,
  output logic [W-1:0] enc_q,
  output logic         ovr_q
);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] enc_d;

  always_comb begin
    case (fmt_i)
      FMT_TWOS: enc_d = word_i ^ MSB_MASK;
      FMT_GRAY: enc_d = word_i ^ (word_i >> 1);
      default:  enc_d = word_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      enc_q <= enc_d;
      ovr_q <= ovr_i;
    end
  end
endmodule

// File: rtl/cof_delay.sv
module cof_delay #(
  parameter int DW     = 13,
  parameter int STAGES = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  if (STAGES == 0) begin : g_pass
    assign dout = din;
  end else begin : g_pipe
    logic [DW-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
      end else begin
        pipe_q[0] <= din;
        for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      end
    end

    assign dout = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/cof_lane_pack.sv
module cof_lane_pack #(
  parameter int W = 12
) (
  input  logic           clk,
  input  logic           dav_qclk_i,
  input  logic           ddr_mode_i,
  input  logic [W-1:0]   word_i,
  output logic [W-1:0]   par_o,
  output logic [W/2-1:0] ddr_o,
  output logic           dav_o
);
  localparam int LANES = W / 2;

  for (genvar li = 0; li < LANES; li++) begin : g_lane
    assign ddr_o[li] = ddr_mode_i & (clk ? word_i[2*li] : word_i[2*li+1]);
  end

  assign par_o = ddr_mode_i ? '0 : word_i;
  assign dav_o = ddr_mode_i ? dav_qclk_i : ~clk;
endmodule

// File: rtl/cvt_out_fmt.sv
module cvt_out_fmt
  import cof_pkg::*;
#(
  parameter int W       = 12,
  parameter int LATENCY = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dav_qclk_i,
  input  logic [W-1:0]   smp_i,
  input  logic           ovr_i,
  input  logic [2:0]     pat_sel_i,
  input  logic [W-1:0]   user_pat_i,
  input  logic [1:0]     fmt_sel_i,
  input  logic           pin_mode_i,
  input  logic           dfs_i,
  input  logic           ddr_mode_i,
  output logic [W-1:0]   par_o,
  output logic [W/2-1:0] ddr_o,
  output logic           ovr_o,
  output logic           dav_o
);
  localparam int TAIL = LATENCY - 2;
  localparam int DW   = W + 1;

  fmt_e         fmt_res;
  logic [W-1:0] s1_word;
  logic         s1_ovr;
  fmt_e         s1_fmt;
  logic [W-1:0] ramp_q;
  logic         phase_q;
  logic [W-1:0] enc_word;
  logic         enc_ovr;
  logic [DW-1:0] tail_out;

  always_comb begin
    if (pin_mode_i) begin
      fmt_res = dfs_i ? FMT_TWOS : FMT_OBIN;
    end else begin
      case (fmt_sel_i)
        2'b01:   fmt_res = FMT_TWOS;
        2'b10:   fmt_res = FMT_GRAY;
        default: fmt_res = FMT_OBIN;
      endcase
    end
  end

  cof_pattern_gen #(.W(W)) u_pat (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_i      (smp_i),
    .ovr_i      (ovr_i),
    .pat_sel_i  (pat_sel_i),
    .user_pat_i (user_pat_i),
    .fmt_i      (fmt_res),
    .word_q     (s1_word),
    .ovr_q      (s1_ovr),
    .fmt_q      (s1_fmt),
    .ramp_q     (ramp_q),
    .phase_q    (phase_q)
  );

  cof_encoder #(.W(W)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .word_i (s1_word),
    .ovr_i  (s1_ovr),
    .fmt_i  (s1_fmt),
    .enc_q  (enc_word),
    .ovr_q  (enc_ovr)
  );

  cof_delay #(.DW(DW), .STAGES(TAIL)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({enc_ovr, enc_word}),
    .dout  (tail_out)
  );

  assign ovr_o = tail_out[W];

  cof_lane_pack #(.W(W)) u_pack (
    .clk        (clk),
    .dav_qclk_i (dav_qclk_i),
    .ddr_mode_i (ddr_mode_i),
    .word_i     (tail_out[W-1:0]),
    .par_o      (par_o),
    .ddr_o      (ddr_o),
    .dav_o      (dav_o)
  );
endmodule

// File: rtl/cvt_out_fmt_chk.sv
module cvt_out_fmt_chk
  import cof_pkg::*;
#(
  parameter int W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ddr_mode_i,
  input logic [W-1:0]   par_o,
  input logic [W/2-1:0] ddr_o,
  input logic           ovr_o,
  input logic [W-1:0]   s1_word,
  input fmt_e           s1_fmt,
  input logic [W-1:0]   enc_word,
  input logic [W-1:0]   ramp_q
);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (par_o == '0 && ddr_o == '0 && !ovr_o));

  // R9
  ddr_par_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_mode_i |-> (par_o == '0));

  // R10
  par_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_mode_i |-> (ddr_o == '0));

  // R7
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (ramp_q == $past(ramp_q) + 1'b1));

  // R3
  twos_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(s1_fmt) == FMT_TWOS) |-> (enc_word == ($past(s1_word) ^ MSB_MASK)));
endmodule

bind cvt_out_fmt cvt_out_fmt_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ddr_mode_i (ddr_mode_i),
  .par_o      (par_o),
  .ddr_o      (ddr_o),
  .ovr_o      (ovr_o),
  .s1_word    (s1_word),
  .s1_fmt     (s1_fmt),
  .enc_word   (enc_word),
  .ramp_q     (ramp_q)
);

// File: tb/cvt_out_fmt_bench.sv
`timescale 1ns/1ps
module cvt_out_fmt_bench;
  localparam int W   = 12;
  localparam int LAT = 14;

  logic         clk = 1'b0;
  logic         qclk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] smp_i = '0;
  logic         ovr_i = 1'b0;
  logic [2:0]   pat_sel_i = 3'b000;
  logic [W-1:0] user_pat_i = '0;
  logic [1:0]   fmt_sel_i = 2'b00;
  logic         pin_mode_i = 1'b0;
  logic         dfs_i = 1'b0;
  logic         ddr_mode_i = 1'b0;
  logic [W-1:0] par_o;
  logic [W/2-1:0] ddr_o;
  logic         ovr_o;
  logic         dav_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  initial begin
    #5;
    forever #10 qclk = ~qclk;
  end

  cvt_out_fmt u_cvt_out_fmt (
    .clk(clk), .rst_n(rst_n), .dav_qclk_i(qclk), .smp_i(smp_i), .ovr_i(ovr_i),
    .pat_sel_i(pat_sel_i), .user_pat_i(user_pat_i), .fmt_sel_i(fmt_sel_i),
    .pin_mode_i(pin_mode_i), .dfs_i(dfs_i), .ddr_mode_i(ddr_mode_i),
    .par_o(par_o), .ddr_o(ddr_o), .ovr_o(ovr_o), .dav_o(dav_o)
  );

  // Behavioural reference: queue of expected {ovr, word}, edge counter
  logic [W:0] expq [$];
  int edges = 0;

  function automatic logic [W:0] model(int n);
    logic [W-1:0] w;
    logic         o;
    int           code;
    o = ovr_i;
    case (pat_sel_i)
      3'b001: w = 12'h800;
      3'b010: w = 12'hFFF;
      3'b011: w = 12'h000;
      3'b100: w = (n % 2 == 0) ? 12'hAAA : 12'h555;
      3'b101: w = user_pat_i;
      3'b110: w = 12'(n % 4096);
      default: w = smp_i;
    endcase
    if (pat_sel_i != 3'b000 && pat_sel_i != 3'b111) o = 1'b0;
    if (pin_mode_i) code = dfs_i ? 1 : 0;
    else code = (fmt_sel_i == 2'b11) ? 0 : int'(fmt_sel_i);
    if (code == 1) w[W-1] = ~w[W-1];
    else if (code == 2) w = w ^ (w >> 1);
    return {o, w};
  endfunction

  initial begin
    for (int i = 0; i < LAT; i++) expq.push_back('0);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      expq.push_back(model(edges));
      void'(expq.pop_front());
      edges++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare every clock, once in each half period
  always @(posedge clk) begin
    logic [W:0] e;
    logic [W/2-1:0] lanes;
    if (!done) begin
      #8;
      e = expq[0];
      chk("R2/R8 ovr", 32'(ovr_o), 32'(e[W]));
      if (ddr_mode_i) begin
        for (int l = 0; l < W/2; l++) lanes[l] = e[2*l];
        chk("R9 high half", 32'(ddr_o), 32'(lanes));
        chk("R9 par quiet", 32'(par_o), 0);
        chk("R11 ddr strobe", 32'(dav_o), 1);
      end else begin
        chk("R2/R10 word", 32'(par_o), 32'(e[W-1:0]));
        chk("R10 lanes quiet", 32'(ddr_o), 0);
        chk("R11 par strobe", 32'(dav_o), 0);
      end
      #10;
      if (ddr_mode_i) begin
        for (int l = 0; l < W/2; l++) lanes[l] = e[2*l+1];
        chk("R9 low half", 32'(ddr_o), 32'(lanes));
        chk("R11 ddr strobe low", 32'(dav_o), 0);
      end else begin
        chk("R10 word low half", 32'(par_o), 32'(e[W-1:0]));
        chk("R11 par strobe low", 32'(dav_o), 1);
      end
    end
  end

  task automatic phase(int n, logic [2:0] pat, logic [1:0] fmt, logic pin, logic dfs, logic ddr);
    @(negedge clk);
    pat_sel_i = pat; fmt_sel_i = fmt; pin_mode_i = pin; dfs_i = dfs; ddr_mode_i = ddr;
    for (int i = 0; i < n; i++) begin
      smp_i = 12'($urandom);
      ovr_i = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic mixed(int n, logic ddr);
    @(negedge clk);
    ddr_mode_i = ddr;
    for (int i = 0; i < n; i++) begin
      smp_i      = 12'($urandom);
      ovr_i      = 1'($urandom);
      pat_sel_i  = 3'($urandom);
      fmt_sel_i  = 2'($urandom);
      pin_mode_i = 1'($urandom);
      dfs_i      = 1'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    #1;
    // R1: reset state while reset held
    repeat (3) @(negedge clk);
    chk("R1 par", 32'(par_o), 0);
    chk("R1 ovr", 32'(ovr_o), 0);
    chk("R1 lanes", 32'(ddr_o), 0);
    rst_n = 1'b1;
    user_pat_i = 12'h3C5;
    phase(40, 3'b000, 2'b00, 0, 0, 0);   // R3 offset binary
    phase(40, 3'b000, 2'b01, 0, 0, 0);   // R3 two's complement
    phase(40, 3'b000, 2'b10, 0, 0, 0);   // R3 Gray
    phase(30, 3'b000, 2'b11, 0, 0, 0);   // R3 spare code
    phase(30, 3'b000, 2'b10, 1, 0, 0);   // R4 pin mode, Gray ignored
    phase(30, 3'b000, 2'b10, 1, 1, 0);   // R4 pin mode two's
    phase(20, 3'b001, 2'b00, 0, 0, 0);   // R5 midscale
    phase(20, 3'b010, 2'b01, 0, 0, 0);   // R5 ones
    phase(20, 3'b011, 2'b10, 0, 0, 0);   // R5 zeros
    phase(20, 3'b101, 2'b00, 0, 0, 0);   // R5 user
    phase(20, 3'b111, 2'b00, 0, 0, 0);   // R5 spare off
    phase(30, 3'b100, 2'b00, 0, 0, 0);   // R6 checkerboard
    phase(30, 3'b110, 2'b00, 0, 0, 0);   // R7 ramp
    phase(4200, 3'b110, 2'b10, 0, 0, 1); // R7 wrap, R9 DDR
    user_pat_i = 12'hA0F;
    phase(40, 3'b000, 2'b01, 0, 0, 1);   // R9 DDR random
    mixed(400, 1'b0);                    // R2/R8 per-sample config
    mixed(400, 1'b1);
    phase(LAT + 2, 3'b000, 2'b00, 0, 0, 0);
    done = 1'b1;
    #5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 60000);
    errors++;
    $display("FAIL watchdog expired time=%0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule